// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects sixteen interrupt requests for an 8-bit processor that takes its interrupt vector from the data bus. Each request input can be configured as level-sensitive or as edge-latched. A mask register gates the requests. A priority-group register lifts a chosen subset of inputs above all the others. An in-service register records nested service levels. The controller drives one active-high INT line. The processor answers INT with a one-cycle acknowledge strobe. In that same cycle it receives an 8-bit vector. Later it sends a one-cycle end-of-interrupt strobe when the handler returns.

Software reaches the controller through four byte-wide ports, selected by a 2-bit address with separate read and write strobes. After reset the block is in a setup phase. In this phase, writes to ports 0 and 1 set the trigger mode of each input. The first write to port 3 stores the vector base and closes the setup phase until the next reset. From then on, ports 0 and 1 load the priority group and port 3 loads the high byte of the mask. When nothing qualifies at acknowledge time, the controller returns the bare vector base. It then holds INT low until the next end-of-interrupt.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, INT is low, the in-service register reads 0x0000 (ports 0 and 1), the mask reads 0xFFFF (ports 2 and 3), every input is in level mode, and the priority group is empty.
- R2: A level-mode input's request follows its pin. Raising an unmasked pin, with nothing in service, sets INT one clock edge later. Dropping the pin before acknowledge withdraws the request.
- R3: An edge-mode input (trigger-mode bit = 1) latches on a low-to-high pin transition and stays requested after the pin falls. INT rises two edges after the pin rises. The latch is cleared when that level is acknowledged.
- R4: Writes to address 0 and 1 load the low and high byte of the trigger-mode register during setup, and of the priority-group register afterwards. Address 2 always writes mask bits 7:0. The first address-3 write ends setup for good. Later address-3 writes load mask bits 15:8. Reads at 0 and 1 return in-service bits 7:0 and 15:8, and reads at 2 and 3 return mask bits 7:0 and 15:8.
- R5: Only bits 7:5 of the vector-base write are kept. During an acknowledge the vector is {base[7:5], level[3:0], 0}.
- R6: A higher input index has higher priority. INT is raised only when the highest eligible (requested and unmasked) input is above the highest in-service level. An acknowledge sets the chosen level's in-service bit.
- R7: A masked input (mask bit = 1) neither raises INT nor is chosen at acknowledge.
- R8: If any eligible request or in-service level lies in the priority group, only grouped levels are compared. A grouped request wins over any higher ungrouped one, and a grouped level in service blocks all ungrouped requests.
- R9: An acknowledge with no qualifying level returns {base[7:5], 00000}, sets no in-service bit, and holds INT low until an end-of-interrupt. That end-of-interrupt clears only the spurious condition.
- R10: An end-of-interrupt clears the highest in-service bit, choosing among grouped bits first. An end-of-interrupt with nothing in service changes nothing.
- R11: When the trigger-mode register is rewritten, inputs now in level mode reload from their pins, inputs staying in edge mode keep their latch, and inputs newly in edge mode start with no request.
- R12: INT is registered. It is low on the edge that ends an acknowledge or end-of-interrupt cycle, and is re-evaluated from the updated state on the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 16 | Request pins, synchronous to clk, bit 15 highest priority |
| reg_addr | input | 2 | Register port select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, zero when reg_rd is low |
| iack | input | 1 | One-cycle interrupt acknowledge |
| eoi | input | 1 | One-cycle end of interrupt |
| vector | output | 8 | Vector, valid in the iack cycle |
| int_o | output | 1 | Interrupt request to the processor |

## Verification
A level-mode request shows on INT one edge after the pin changes. An edge-mode request shows two edges after the rise, because the latch sits between the pin and the arbiter. The vector and read data are combinational, so the bench samples them shortly after driving the strobe and before the clock edge. INT is checked at the falling edge after the acknowledge or end-of-interrupt edge, where it must be low. It is checked again one edge later, where it shows the re-evaluated state. All stimulus changes at falling edges, and every check is placed by counting those registers.

// File: rtl/vic_pkg.sv
// Package: shared widths, types and the priority encoder for the
// vectored interrupt controller. Assumes 16 sources (two register bytes).
package vic_pkg;
    localparam int N_SRC    = 16;
    localparam int LVL_W    = $clog2(N_SRC);
    localparam int BYTE_W   = 8;
    localparam int BASE_W   = BYTE_W - LVL_W - 1;
    localparam int N_BYTES  = N_SRC / BYTE_W;

    typedef logic [N_SRC-1:0] src_vec_t;

    // Register port numbers; port 3 doubles as vector base during setup.
    typedef enum logic [1:0] {
        P_SVC_LO  = 2'd0,
        P_SVC_HI  = 2'd1,
        P_MASK_LO = 2'd2,
        P_MASK_HI = 2'd3
    } port_sel_t;

    // Index of the highest set bit (0 when none is set).
    function automatic logic [LVL_W-1:0] top_idx(input src_vec_t v);
        logic [LVL_W-1:0] r;
        r = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (v[i]) r = LVL_W'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/vic_req_bank.sv
// Request bank: turns raw pins into per-source requests.
// Level-mode sources pass the pin straight through; edge-mode sources
// hold a latch set by a rising pin and cleared on acknowledge.
// Assumes pins are synchronous to clk. Latches of level-mode sources are
// kept at zero, so a source newly switched to edge mode starts clear.
module vic_req_bank
    import vic_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t pins,
    input  src_vec_t edge_mode,
    input  src_vec_t edge_mode_nxt,
    input  logic     mode_wr,
    input  src_vec_t ack_clr,
    output src_vec_t req
);
    src_vec_t pin_q;
    src_vec_t lat_q;
    src_vec_t rise;
    src_vec_t keep_mask;

    assign rise      = pins & ~pin_q;
    assign keep_mask = mode_wr ? edge_mode_nxt : edge_mode;

    // Delayed pin copy for rising-edge detection.
    always_ff @(posedge clk) begin
        pin_q <= pins;
    end

    // Edge latches: set on rise, clear on acknowledge, drop for level bits.
    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= ((lat_q | (rise & edge_mode)) & ~ack_clr) & keep_mask;
    end

    // Effective request per source.
    assign req = (edge_mode & lat_q) | (~edge_mode & pins);

    // R3: a latched edge request survives unless acknowledged or remapped.
    a_r3_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr |=> ((($past(lat_q) & ~$past(ack_clr)) & ~lat_q) == '0));
endmodule

// File: rtl/vic_arbiter.sv
// Arbiter: picks the level an acknowledge would take and the level an
// end-of-interrupt would retire. Purely combinational. The grouped tier is
// compared on its own whenever it holds a request or an in-service bit.
module vic_arbiter
    import vic_pkg::*;
(
    input  src_vec_t           req,
    input  src_vec_t           mask,
    input  src_vec_t           group,
    input  src_vec_t           in_svc,
    output logic               win_valid,
    output logic [LVL_W-1:0]   win_lvl,
    output logic               ret_valid,
    output logic [LVL_W-1:0]   ret_lvl
);
    src_vec_t elig;
    src_vec_t g_elig;
    src_vec_t g_svc;

    assign elig   = req & ~mask;
    assign g_elig = elig & group;
    assign g_svc  = in_svc & group;

    // Winner selection across the two tiers.
    always_comb begin
        win_valid = 1'b0;
        win_lvl   = '0;
        if (g_elig != '0) begin
            win_lvl   = top_idx(g_elig);
            win_valid = (g_svc == '0) || (win_lvl > top_idx(g_svc));
        end else if ((elig != '0) && (g_svc == '0)) begin
            win_lvl   = top_idx(elig);
            win_valid = (in_svc == '0) || (win_lvl > top_idx(in_svc));
        end
    end

    // Level to retire on end-of-interrupt, grouped bits first.
    always_comb begin
        ret_valid = (in_svc != '0);
        ret_lvl   = (g_svc != '0) ? top_idx(g_svc) : top_idx(in_svc);
    end
endmodule

// File: rtl/vic_cfg_regs.sv
// Configuration registers and software ports. Holds trigger mode, group,
// mask and vector base, plus the one-way setup flag that remaps ports 0, 1
// and 3. Read data is combinational and zero without a read strobe.
module vic_cfg_regs
    import vic_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         addr,
    input  logic               wr,
    input  logic               rd,
    input  logic [BYTE_W-1:0]  wdata,
    input  src_vec_t           in_svc,
    output src_vec_t           edge_mode,
    output src_vec_t           edge_mode_nxt,
    output logic               mode_wr,
    output src_vec_t           group,
    output src_vec_t           mask,
    output logic [BASE_W-1:0]  base,
    output logic [BYTE_W-1:0]  rdata
);
    logic     setup_done;
    logic     byte_hi;
    port_sel_t sel;

    assign sel     = port_sel_t'(addr);
    assign byte_hi = addr[0];
    assign mode_wr = wr && !setup_done && !addr[1];

    // Next trigger-mode value when a setup-phase write hits port 0 or 1.
    always_comb begin
        edge_mode_nxt = edge_mode;
        if (mode_wr) edge_mode_nxt[BYTE_W*int'(byte_hi) +: BYTE_W] = wdata;
    end

    // Register updates by port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_mode  <= '0;
            group      <= '0;
            mask       <= '1;
            base       <= '0;
            setup_done <= 1'b0;
        end else if (wr) begin
            case (sel)
                P_SVC_LO, P_SVC_HI: begin
                    if (setup_done) group[BYTE_W*int'(byte_hi) +: BYTE_W] <= wdata;
                    else            edge_mode <= edge_mode_nxt;
                end
                P_MASK_LO: mask[BYTE_W-1:0] <= wdata;
                P_MASK_HI: begin
                    if (setup_done) mask[N_SRC-1:BYTE_W] <= wdata;
                    else begin
                        base       <= wdata[BYTE_W-1 -: BASE_W];
                        setup_done <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Read mux: in-service bytes on 0/1, mask bytes on 2/3.
    always_comb begin
        rdata = '0;
        if (rd) begin
            if (addr[1]) rdata = mask[BYTE_W*int'(byte_hi) +: BYTE_W];
            else         rdata = in_svc[BYTE_W*int'(byte_hi) +: BYTE_W];
        end
    end

    // R4: once setup ends it stays ended until reset.
    a_r4_setup_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        setup_done |=> setup_done);

    // R1: the first cycle out of reset sees every source masked.
    a_r1_mask_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask == '1));
endmodule

// File: rtl/vec_irq_ctrl.sv
// Top: 16-source prioritized vectored interrupt controller. Holds the
// in-service register, the spurious flag and the registered INT output,
// and ties the request bank, arbiter and register ports together.
// Assumes iack and eoi are single-cycle and never high together.
module vec_irq_ctrl
    import vic_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] irq_in,
    input  logic [1:0]  reg_addr,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        iack,
    input  logic        eoi,
    output logic [7:0]  vector,
    output logic        int_o
);
    src_vec_t           req;
    src_vec_t           in_svc;
    src_vec_t           edge_mode;
    src_vec_t           edge_mode_nxt;
    src_vec_t           group;
    src_vec_t           mask;
    src_vec_t           ack_clr;
    logic               mode_wr;
    logic [BASE_W-1:0]  base;
    logic               win_valid;
    logic [LVL_W-1:0]   win_lvl;
    logic               ret_valid;
    logic [LVL_W-1:0]   ret_lvl;
    logic               spur;
    logic               take;

    assign take    = iack && win_valid;
    assign ack_clr = take ? (src_vec_t'(1) << win_lvl) : '0;

    vic_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
        .wdata(reg_wdata), .in_svc(in_svc), .edge_mode(edge_mode),
        .edge_mode_nxt(edge_mode_nxt), .mode_wr(mode_wr), .group(group),
        .mask(mask), .base(base), .rdata(reg_rdata)
    );

    vic_req_bank u_req (
        .clk(clk), .rst_n(rst_n), .pins(irq_in), .edge_mode(edge_mode),
        .edge_mode_nxt(edge_mode_nxt), .mode_wr(mode_wr), .ack_clr(ack_clr),
        .req(req)
    );

    vic_arbiter u_arb (
        .req(req), .mask(mask), .group(group), .in_svc(in_svc),
        .win_valid(win_valid), .win_lvl(win_lvl),
        .ret_valid(ret_valid), .ret_lvl(ret_lvl)
    );

    // In-service register: set on acknowledge, retire on end-of-interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n)                            in_svc <= '0;
        else if (take)                         in_svc <= in_svc | ack_clr;
        else if (eoi && !spur && ret_valid)    in_svc <= in_svc & ~(src_vec_t'(1) << ret_lvl);
    end

    // Spurious flag: set by an empty acknowledge, cleared by end-of-interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n)                  spur <= 1'b0;
        else if (iack && !win_valid) spur <= 1'b1;
        else if (eoi)                spur <= 1'b0;
    end

    // Registered INT, held low through strobe cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) int_o <= 1'b0;
        else        int_o <= win_valid && !spur && !iack && !eoi;
    end

    // Vector: base, chosen level, zero LSB.
    assign vector = {base, (win_valid ? win_lvl : LVL_W'(0)), 1'b0};

    // R12: INT is low right after an acknowledge.
    a_r12_int_low_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        iack |=> !int_o);

    // R12: strobes never overlap.
    a_r12_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(iack && eoi));

    // R6: a granted acknowledge adds exactly one in-service level.
    a_r6_ack_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> ($countones(in_svc) == $past($countones(in_svc)) + 1));

    // R10: a real end-of-interrupt retires exactly one level.
    a_r10_eoi_retires_one: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !spur && (in_svc != '0)) |=> ($countones(in_svc) + 1 == $past($countones(in_svc))));

    // R9: while spurious, INT stays low.
    a_r9_spur_blocks_int: assert property (@(posedge clk) disable iff (!rst_n)
        spur |=> !int_o);

    // R8: with a grouped request eligible, the winner is grouped.
    a_r8_group_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (take && ((req & ~mask & group) != '0)) |-> group[win_lvl]);
endmodule

// File: tb/vec_irq_ctrl_test.sv
// Self-checking bench: a vector table of single-source patterns, then
// directed tests for reset, edge latching, masking, nesting, grouping,
// spurious acknowledge and trigger-mode rewrites.
module vec_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_in = '0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        iack = 1'b0;
    logic        eoi = 1'b0;
    logic [7:0]  vector;
    logic        int_o;
    int          n_chk = 0;
    int          n_err = 0;
    logic        done = 1'b0;

    always #10 clk = ~clk;

    vec_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .iack(iack), .eoi(eoi), .vector(vector),
        .int_o(int_o)
    );

    // Table row: {pins[15:0], expected INT, expected vector}; base 0xA0.
    localparam int N_ROWS = 6;
    localparam logic [24:0] ROWS [N_ROWS] = '{
        {16'h0001, 1'b1, 8'hA0},
        {16'h0020, 1'b1, 8'hAA},
        {16'h8000, 1'b1, 8'hBE},
        {16'h0300, 1'b1, 8'hB2},
        {16'h0000, 1'b0, 8'h00},
        {16'h1234, 1'b1, 8'hB8}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic do_iack(output logic [7:0] v);
        iack = 1'b1;
        #1 v = vector;
        @(negedge clk);
        iack = 1'b0;
    endtask

    task automatic do_eoi();
        eoi = 1'b1;
        @(negedge clk);
        eoi = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] v;
        @(negedge clk);
        do_reset();

        // R1: reset state
        chk("R1 int", int_o, 1'b0);
        rd(2'd2, d); chk("R1 mask lo", d, 8'hFF);
        rd(2'd3, d); chk("R1 mask hi", d, 8'hFF);
        rd(2'd0, d); chk("R1 svc lo", d, 8'h00);
        irq_in = 16'h0010; cyc(2);
        chk("R1/R7 masked after reset", int_o, 1'b0);
        irq_in = '0;

        // R4/R5: setup, vector base keeps bits 7:5, then mask bytes
        wr(2'd0, 8'h02);
        wr(2'd1, 8'h00);
        wr(2'd3, 8'hB7);
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h00);
        rd(2'd3, d); chk("R4 second port3 write hits mask hi", d, 8'h00);
        rd(2'd2, d); chk("R4 mask lo", d, 8'h00);

        // R2/R5/R6: table of level patterns
        for (int i = 0; i < N_ROWS; i++) begin
            irq_in = ROWS[i][24:9];
            cyc(1);
            chk($sformatf("R2 row%0d int", i), int_o, ROWS[i][8]);
            if (ROWS[i][8]) begin
                do_iack(v);
                chk($sformatf("R5 row%0d vector", i), v, ROWS[i][7:0]);
                chk($sformatf("R12 row%0d int after ack", i), int_o, 1'b0);
                irq_in = '0;
                do_eoi();
                cyc(1);
                chk($sformatf("R2 row%0d int after drop", i), int_o, 1'b0);
            end
            irq_in = '0;
        end

        // R3: edge latch on source 1
        irq_in = 16'h0002; cyc(1);
        irq_in = '0;       cyc(1);
        chk("R3 latched after pin falls", int_o, 1'b1);
        do_iack(v);
        chk("R3 vector", v, 8'hA2);
        do_eoi(); cyc(1);
        chk("R3 latch cleared by ack", int_o, 1'b0);

        // R7: mask gates a request
        wr(2'd2, 8'h01);
        irq_in = 16'h0001; cyc(2);
        chk("R7 masked no int", int_o, 1'b0);
        wr(2'd2, 8'h00); cyc(1);
        chk("R7 unmasked int", int_o, 1'b1);
        irq_in = '0; cyc(1);
        chk("R2 request withdrawn", int_o, 1'b0);

        // R6/R10: nesting
        irq_in = 16'h0008; cyc(1);
        do_iack(v); chk("R6 first vector", v, 8'hA6);
        cyc(1); chk("R6 same level no int", int_o, 1'b0);
        irq_in = 16'h0088; cyc(1);
        chk("R6 higher preempts", int_o, 1'b1);
        do_iack(v); chk("R6 nested vector", v, 8'hAE);
        rd(2'd0, d); chk("R6 two in service", d, 8'h88);
        irq_in = 16'h00A8; cyc(1);
        chk("R6 lower blocked", int_o, 1'b0);
        do_eoi();
        rd(2'd0, d); chk("R10 highest retired", d, 8'h08);
        irq_in = '0;
        do_eoi();
        rd(2'd0, d); chk("R10 second retired", d, 8'h00);
        do_eoi(); cyc(1);
        rd(2'd0, d); chk("R10 empty eoi ignored", d, 8'h00);
        chk("R10 empty eoi int", int_o, 1'b0);

        // R8/R4: priority group after setup
        wr(2'd0, 8'h04);
        irq_in = 16'h0204; cyc(1);
        do_iack(v); chk("R8 grouped wins", v, 8'hA4);
        cyc(1); chk("R8 group in service blocks", int_o, 1'b0);
        irq_in = 16'h0200;
        do_eoi(); cyc(1);
        chk("R8 ungrouped after group done", int_o, 1'b1);
        do_iack(v); chk("R8 ungrouped vector", v, 8'hB2);
        irq_in = '0;
        do_eoi();
        wr(2'd0, 8'h00);

        // R9: spurious acknowledge
        irq_in = 16'h0010; cyc(1);
        chk("R9 pending", int_o, 1'b1);
        irq_in = '0;
        do_iack(v); chk("R9 spurious vector", v, 8'hA0);
        rd(2'd0, d); chk("R9 no in-service set", d, 8'h00);
        irq_in = 16'h0040; cyc(2);
        chk("R9 int held low", int_o, 1'b0);
        do_eoi(); cyc(1);
        chk("R9 int back after eoi", int_o, 1'b1);
        do_iack(v); chk("R9 next vector", v, 8'hAC);
        irq_in = '0;
        do_eoi();

        // R11: trigger-mode rewrite during a fresh setup phase
        do_reset();
        wr(2'd0, 8'h02);
        wr(2'd2, 8'h00);
        irq_in = 16'h0002; cyc(1);
        irq_in = 16'h0004; cyc(1);
        chk("R11 pending", int_o, 1'b1);
        wr(2'd0, 8'h06); cyc(1);
        do_iack(v); chk("R11 new edge source starts clear", v, 8'h02);
        wr(2'd0, 8'h02); cyc(1);
        chk("R11 level source reloads pin", int_o, 1'b1);
        do_iack(v); chk("R11 reloaded vector", v, 8'h04);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule